// File: doc/BRIEF.md
# Chained Operand Register File

This block holds the working operands of a binary-field elliptic-curve datapath. It has six equal-width registers. An external controller gives each one its own load enable. The registers are not addressed. Each one has a fixed source:

- The accumulator register (A) chooses its next value from the arithmetic result, an external data word, the shift register, or one of three constants.
- The shift register (B) either copies the accumulator or rotates itself left by one place. Its top bit is exposed as the serial operand bit for a bit-serial field multiplier.
- The four storage registers (C to F) form a chain. Each stage copies the stage before it, so intermediate results can be parked and moved along under controller command.

The controller drives the enables and selects. The arithmetic unit reads the serial bit and the parallel operand in C, and returns its result on the arithmetic input. The accumulator and the tail of the chain are visible as outputs. A synchronous reset clears every register.

Top module: `operand_regfile`

## Requirements
- R1: A cycle with `rst` high clears all six registers to zero at that clock edge: `data_out`, `serial_bit`, `op_c` and `tail_f` all read zero after it.
- R2: A register whose enable bit is low keeps its value across the edge, whatever the selects and data inputs are. Enable bit 0 is A, bit 1 is B, and so on up to bit 5 for F.
- R3: With `en[0]` high, `a_sel` chooses the next value of A: code 0 takes `alu_in`, code 1 takes `ext_in`, code 2 takes B. Codes 6 and 7 leave A unchanged.
- R4: With `en[0]` high, `a_sel` codes 3, 4 and 5 load the parameter constants K0, K1 and K2 into A.
- R5: With `en[1]` high, `b_rot` = 0 copies A into B. `b_rot` = 1 rotates B left by one place, so that bit W-1 moves to bit 0.
- R6: `serial_bit` always equals the most significant bit of B.
- R7: With its own enable high, C loads B, D loads C, E loads D and F loads E. `op_c` shows C and `tail_f` shows F.
- R8: When several enables are high in one cycle, every register takes a source value from before the edge. A full C-to-F shift therefore completes in one clock, and A and B can swap contents in one clock.
- R9: `rst` takes priority over every enable and select in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 6 | Load enables; bit 0 = A … bit 5 = F |
| a_sel | input | 3 | Source code for A (0 arithmetic, 1 external, 2 B, 3–5 constants, 6–7 hold) |
| b_rot | input | 1 | B source: 0 = A, 1 = rotate left |
| alu_in | input | W | Result from the arithmetic unit |
| ext_in | input | W | External data word |
| data_out | output | W | Current value of A |
| serial_bit | output | 1 | MSB of B, the serial multiplier operand |
| op_c | output | W | Current value of C (parallel operand) |
| tail_f | output | W | Current value of F |

## Verification
Every register change is due exactly one clock after the cycle whose enables and selects cause it, because each register has a single flop stage and there is no other pipeline. The bench drives inputs on the falling edge. It waits for the next rising edge and samples two time units later. On that cycle it compares all four outputs with a bench model that steps once per cycle from the values held before the edge. Full rotations of every single-bit pattern are checked one cycle at a time, so an off-by-one in the rotation shows up at the exact step where it occurs.

// File: rtl/oprf_pkg.sv
package oprf_pkg;

   localparam int NUM_REGS = 6;
   localparam int IDX_A    = 0;
   localparam int IDX_B    = 1;
   localparam int IDX_C    = 2;

   typedef enum logic [2:0] {
      ASRC_ARITH = 3'd0,
      ASRC_EXT   = 3'd1,
      ASRC_SHIFT = 3'd2,
      ASRC_K0    = 3'd3,
      ASRC_K1    = 3'd4,
      ASRC_K2    = 3'd5,
      ASRC_KEEP6 = 3'd6,
      ASRC_KEEP7 = 3'd7
   } a_src_e;

endpackage

// File: rtl/oprf_stage.sv
module oprf_stage #(
   parameter int W = 163
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (ld) q <= d;
   end

   assert_stage_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !ld |=> $stable(q));

   assert_stage_clear_R1: assert property (@(posedge clk)
      rst |=> (q == '0));

endmodule

// File: rtl/oprf_a_mux.sv
module oprf_a_mux
   import oprf_pkg::*;
#(
   parameter int           W  = 163,
   parameter logic [W-1:0] K0 = '0,
   parameter logic [W-1:0] K1 = '0,
   parameter logic [W-1:0] K2 = '0
) (
   input  logic [2:0]   sel,
   input  logic [W-1:0] arith,
   input  logic [W-1:0] ext,
   input  logic [W-1:0] shreg,
   output logic [W-1:0] nxt,
   output logic         valid
);

   always_comb begin
      valid = 1'b1;
      nxt   = '0;
      unique case (a_src_e'(sel))
         ASRC_ARITH: nxt = arith;
         ASRC_EXT:   nxt = ext;
         ASRC_SHIFT: nxt = shreg;
         ASRC_K0:    nxt = K0;
         ASRC_K1:    nxt = K1;
         ASRC_K2:    nxt = K2;
         default:    valid = 1'b0;
      endcase
   end

endmodule

// File: rtl/oprf_b_rot.sv
module oprf_b_rot #(
   parameter int W = 163
) (
   input  logic         rot,
   input  logic [W-1:0] from_a,
   input  logic [W-1:0] cur,
   output logic [W-1:0] nxt
);

   logic [W-1:0] rotated;

   assign rotated = {cur[W-2:0], cur[W-1]};
   assign nxt     = rot ? rotated : from_a;

endmodule

// File: rtl/oprf_chain.sv
module oprf_chain #(
   parameter int W     = 163,
   parameter int DEPTH = 4
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [DEPTH-1:0]      ld,
   input  logic [W-1:0]          head,
   output logic [DEPTH-1:0][W-1:0] taps
);

   logic [DEPTH:0][W-1:0] link;

   assign link[0] = head;

   for (genvar k = 0; k < DEPTH; k++) begin : g_stage
      oprf_stage #(.W(W)) stage_i (
         .clk (clk),
         .rst (rst),
         .ld  (ld[k]),
         .d   (link[k]),
         .q   (link[k+1])
      );
      assign taps[k] = link[k+1];

      assert_chain_copy_R7: assert property (@(posedge clk) disable iff (rst)
         ld[k] |=> (taps[k] == $past(link[k])));
   end

endmodule

// File: rtl/operand_regfile.sv
module operand_regfile
   import oprf_pkg::*;
#(
   parameter int           W  = 163,
   parameter logic [W-1:0] K0 = '0,
   parameter logic [W-1:0] K1 = W'(1),
   parameter logic [W-1:0] K2 = W'(8'hC9)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_REGS-1:0] en,
   input  logic [2:0]          a_sel,
   input  logic                b_rot,
   input  logic [W-1:0]        alu_in,
   input  logic [W-1:0]        ext_in,
   output logic [W-1:0]        data_out,
   output logic                serial_bit,
   output logic [W-1:0]        op_c,
   output logic [W-1:0]        tail_f
);

   localparam int CHAIN = NUM_REGS - IDX_C;

   if (W < 8) begin : g_bad_width
      $error("operand_regfile: W must be at least 8");
   end
   if (CHAIN < 1) begin : g_bad_chain
      $error("operand_regfile: chain needs at least one stage");
   end

   logic [W-1:0] reg_a, reg_b, a_nxt, b_nxt;
   logic         a_valid;
   logic [CHAIN-1:0][W-1:0] taps;

   oprf_a_mux #(.W(W), .K0(K0), .K1(K1), .K2(K2)) a_mux_i (
      .sel   (a_sel),
      .arith (alu_in),
      .ext   (ext_in),
      .shreg (reg_b),
      .nxt   (a_nxt),
      .valid (a_valid)
   );

   oprf_stage #(.W(W)) a_reg_i (
      .clk (clk),
      .rst (rst),
      .ld  (en[IDX_A] & a_valid),
      .d   (a_nxt),
      .q   (reg_a)
   );

   oprf_b_rot #(.W(W)) b_rot_i (
      .rot    (b_rot),
      .from_a (reg_a),
      .cur    (reg_b),
      .nxt    (b_nxt)
   );

   oprf_stage #(.W(W)) b_reg_i (
      .clk (clk),
      .rst (rst),
      .ld  (en[IDX_B]),
      .d   (b_nxt),
      .q   (reg_b)
   );

   oprf_chain #(.W(W), .DEPTH(CHAIN)) chain_i (
      .clk  (clk),
      .rst  (rst),
      .ld   (en[NUM_REGS-1:IDX_C]),
      .head (reg_b),
      .taps (taps)
   );

   assign data_out   = reg_a;
   assign serial_bit = reg_b[W-1];
   assign op_c       = taps[0];
   assign tail_f     = taps[CHAIN-1];

   assert_a_keep_R3: assert property (@(posedge clk) disable iff (rst)
      (en[IDX_A] && a_sel[2:1] == 2'b11) |=> $stable(data_out));

   assert_a_from_b_R3: assert property (@(posedge clk) disable iff (rst)
      (en[IDX_A] && a_sel == 3'd2) |=> (data_out == $past(reg_b)));

   assert_a_const_R4: assert property (@(posedge clk) disable iff (rst)
      (en[IDX_A] && a_sel == 3'd4) |=> (data_out == K1));

   assert_b_rotate_R5: assert property (@(posedge clk) disable iff (rst)
      (en[IDX_B] && b_rot) |=>
         (reg_b == {$past(reg_b[W-2:0]), $past(reg_b[W-1])}));

   assert_swap_R8: assert property (@(posedge clk) disable iff (rst)
      (en[IDX_B] && !b_rot && en[IDX_A] && a_sel == 3'd2) |=>
         (data_out == $past(reg_b) && reg_b == $past(data_out)));

   assert_reset_wins_R9: assert property (@(posedge clk)
      rst |=> (data_out == '0 && !serial_bit && tail_f == '0));

endmodule

// File: tb/operand_regfile_tb.sv
module operand_regfile_tb_top;

   localparam int           W  = 13;
   localparam logic [W-1:0] K0 = 13'h0A5;
   localparam logic [W-1:0] K1 = 13'h001;
   localparam logic [W-1:0] K2 = 13'h1C9;

   logic         clk = 1'b0;
   logic         rst;
   logic [5:0]   en;
   logic [2:0]   a_sel;
   logic         b_rot;
   logic [W-1:0] alu_in, ext_in, data_out, op_c, tail_f;
   logic         serial_bit;

   logic [W-1:0] ma, mb, mc, md, me, mf;
   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   operand_regfile #(.W(W), .K0(K0), .K1(K1), .K2(K2)) dut_i (
      .clk(clk), .rst(rst), .en(en), .a_sel(a_sel), .b_rot(b_rot),
      .alu_in(alu_in), .ext_in(ext_in), .data_out(data_out),
      .serial_bit(serial_bit), .op_c(op_c), .tail_f(tail_f)
   );

   function automatic logic [W-1:0] rotl(input logic [W-1:0] v);
      return {v[W-2:0], v[W-1]};
   endfunction

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic r, input logic [5:0] e, input logic [2:0] s,
                      input logic br, input logic [W-1:0] alu, input logic [W-1:0] ext,
                      input string tag);
      logic [W-1:0] na, nb, nc, nd, ne, nf;
      @(negedge clk);
      rst = r; en = e; a_sel = s; b_rot = br; alu_in = alu; ext_in = ext;
      na = ma; nb = mb; nc = mc; nd = md; ne = me; nf = mf;
      if (r) begin
         na = '0; nb = '0; nc = '0; nd = '0; ne = '0; nf = '0;
      end else begin
         if (e[0]) begin
            case (s)
               3'd0: na = alu;
               3'd1: na = ext;
               3'd2: na = mb;
               3'd3: na = K0;
               3'd4: na = K1;
               3'd5: na = K2;
               default: na = ma;
            endcase
         end
         if (e[1]) nb = br ? rotl(mb) : ma;
         if (e[2]) nc = mb;
         if (e[3]) nd = mc;
         if (e[4]) ne = md;
         if (e[5]) nf = me;
      end
      ma = na; mb = nb; mc = nc; md = nd; me = ne; mf = nf;
      @(posedge clk);
      #2;
      chk(tag, data_out, ma);
      chk("R6", W'(serial_bit), W'(mb[W-1]));
      chk(tag, op_c, mc);
      chk(tag, tail_f, mf);
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      ma = '0; mb = '0; mc = '0; md = '0; me = '0; mf = '0;
      rst = 1'b1; en = '0; a_sel = '0; b_rot = 1'b0; alu_in = '0; ext_in = '0;
      // R1: reset state
      cyc(1'b1, 6'h00, 3'd0, 1'b0, '0, '0, "R1");
      cyc(1'b1, 6'h00, 3'd0, 1'b0, '0, '0, "R1");
      // R3/R4: sweep every A source code
      for (int c = 0; c < 8; c++) begin
         cyc(1'b0, 6'h01, 3'd1, 1'b0, '0, W'(13'h0F0F ^ c), "R3");
         cyc(1'b0, 6'h02, 3'd0, 1'b0, '0, '0, "R5");
         cyc(1'b0, 6'h01, 3'd1, 1'b0, '0, W'(13'h1234 + c), "R3");
         cyc(1'b0, 6'h01, 3'(c), 1'b0, W'(13'h0ABC - c), W'(13'h1555),
             (c >= 3 && c <= 5) ? "R4" : "R3");
      end
      // R5/R6: full rotation of every single-bit pattern
      for (int i = 0; i < W; i++) begin
         cyc(1'b0, 6'h01, 3'd1, 1'b0, '0, W'(1) << i, "R3");
         cyc(1'b0, 6'h02, 3'd0, 1'b0, '0, '0, "R5");
         for (int k = 0; k < W; k++) cyc(1'b0, 6'h02, 3'd0, 1'b1, '0, '0, "R5");
         cyc(1'b0, 6'h01, 3'd2, 1'b0, '0, '0, "R5");
      end
      // R2: no enables, inputs toggling
      for (int k = 0; k < 8; k++)
         cyc(1'b0, 6'h00, 3'(k), k[0], W'(13'h1FFF - k), W'(13'h0777 + k), "R2");
      // R7: move a value stage by stage down the chain
      cyc(1'b0, 6'h01, 3'd1, 1'b0, '0, 13'h1A3C, "R7");
      cyc(1'b0, 6'h02, 3'd0, 1'b0, '0, '0, "R7");
      cyc(1'b0, 6'h04, 3'd0, 1'b0, '0, '0, "R7");
      cyc(1'b0, 6'h08, 3'd0, 1'b0, '0, '0, "R7");
      cyc(1'b0, 6'h10, 3'd0, 1'b0, '0, '0, "R7");
      cyc(1'b0, 6'h20, 3'd0, 1'b0, '0, '0, "R7");
      // R8: fill chain with distinct values, then shift all in one clock
      for (int k = 0; k < 4; k++) begin
         cyc(1'b0, 6'h01, 3'd1, 1'b0, '0, W'(13'h0111 * (k + 1)), "R8");
         cyc(1'b0, 6'h02, 3'd0, 1'b0, '0, '0, "R8");
         cyc(1'b0, 6'h3C, 3'd0, 1'b0, '0, '0, "R8");
      end
      cyc(1'b0, 6'h01, 3'd1, 1'b0, '0, 13'h0EEE, "R8");
      cyc(1'b0, 6'h3F, 3'd2, 1'b0, '0, '0, "R8");
      cyc(1'b0, 6'h03, 3'd2, 1'b0, '0, '0, "R8");
      cyc(1'b0, 6'h3C, 3'd0, 1'b0, '0, '0, "R8");
      // R9: reset with everything enabled
      cyc(1'b1, 6'h3F, 3'd1, 1'b1, 13'h1FFF, 13'h1FFF, "R9");
      cyc(1'b0, 6'h00, 3'd0, 1'b0, '0, '0, "R1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule